// File: doc/BRIEF.md
# Cascadable Signed Multiply-Accumulate Slice

The slice multiplies two signed 18-bit operands and adds the product to two more terms. The first is a 44-bit routed addend with a carry-in. The second is an accumulator operand picked from zero, the slice's own registered result, or a 44-bit cascade input from a neighbouring slice. That operand may first be shifted right arithmetically by 17 places. This lets a chain of slices build wider products, or lets one slice accumulate a running sum on its own. A static mode input changes the multiplier into the sum of two signed 9x9 products, which is useful for short dot products. The result drives both the result output and a cascade output that feeds the next slice in a chain.

Each operand (A, B, and the C addend together with its carry-in), each of the four control bits and the result all pass through a register stage. Data stages have an asynchronous clear, a synchronous clear, a clock enable and a bypass. Control stages have an asynchronous load of a given value, a synchronous load of an inverted constant, an enable and a bypass. A flag beside the result reports when the exact sum does not fit in 44 signed bits. The design uses a single clock.

Top module: `macc_slice`

## Requirements
- R1: While `p_arst_n` is low, `p`, `cdout` and `ovfl` are all zero at once, without waiting for a clock edge.
- R2: With every stage registered and enabled, `p` equals D + C + `cin` + A*B. A and B are signed 18-bit values, and the product and all terms are sign-extended to 44 bits. The result appears after two rising edges.
- R3: When control bit 0 (subtract) is 1, the product is subtracted instead of added, so `p` = D + C + `cin` - product.
- R4: When `dotp` is 1, the product is A[8:0]*B[8:0] + A[17:9]*B[17:9], and each 9-bit field is signed.
- R5: The accumulator operand D is `cdin` when control bit 1 is 1, whatever bit 2 holds. It is the registered result when bit 1 is 0 and bit 2 is 1. It is zero when both are 0.
- R6: When control bit 3 is 1, D is the selected source shifted right arithmetically by 17: the top 17 bits copy bit 43 and the low 27 bits are source bits 43..17.
- R7: `cdout` equals `p` in every cycle.
- R8: `ovfl` is 1 exactly when the signed sum of D, C, `cin` and the signed product is above 2^43-1 or below -2^43. It is registered in the same stage as `p`.
- R9: In a data stage that is not bypassed, a clock edge with the enable low holds the value. A clock edge with the enable high and the synchronous clear low loads zero. The asynchronous clear overrides both.
- R10: A control stage with its asynchronous load low presents its async value at once. Otherwise, at an enabled edge with the synchronous load low, it loads the inverse of its sync data input. At an enabled edge without the synchronous load it loads its D input, and with the enable low it holds.
- R11: A bypassed stage with its enable high passes its next value in the same cycle, with no clock edge. A bypassed stage with its enable low shows its stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| dotp | input | 1 | Static: 1 selects the dual 9x9 product |
| a | input | 18 | Signed multiplicand |
| a_byp | input | 1 | Bypass the A stage |
| a_arst_n | input | 1 | A stage asynchronous clear, active low |
| a_srst_n | input | 1 | A stage synchronous clear, active low |
| a_en | input | 1 | A stage enable |
| b | input | 18 | Signed multiplier |
| b_byp | input | 1 | Bypass the B stage |
| b_arst_n | input | 1 | B stage asynchronous clear, active low |
| b_srst_n | input | 1 | B stage synchronous clear, active low |
| b_en | input | 1 | B stage enable |
| c | input | 44 | Signed routed addend |
| cin | input | 1 | Carry-in, held in the C stage |
| c_byp | input | 1 | Bypass the C stage |
| c_arst_n | input | 1 | C stage asynchronous clear, active low |
| c_srst_n | input | 1 | C stage synchronous clear, active low |
| c_en | input | 1 | C stage enable |
| cdin | input | 44 | Cascade input from a neighbouring slice |
| ctl_d | input | 4 | Controls: bit0 subtract, bit1 take cascade, bit2 take feedback, bit3 shift by 17 |
| ctl_byp | input | 4 | Per-control bypass |
| ctl_aload_n | input | 4 | Per-control asynchronous load, active low |
| ctl_aval | input | 4 | Per-control asynchronous load value |
| ctl_sload_n | input | 4 | Per-control synchronous load, active low |
| ctl_sval_n | input | 4 | Per-control synchronous load data, inverted on load |
| ctl_en | input | 4 | Per-control enable |
| p_byp | input | 1 | Bypass the result stage |
| p_arst_n | input | 1 | Result stage asynchronous clear, active low |
| p_srst_n | input | 1 | Result stage synchronous clear, active low |
| p_en | input | 1 | Result stage enable |
| p | output | 44 | Result |
| cdout | output | 44 | Cascade copy of the result |
| ovfl | output | 1 | Signed overflow of the result sum |

## Verification
A wrong value held in an operand or control stage reaches `p` at the next rising edge. The error therefore shows as a mismatch one edge after the faulty load, and two edges after the input was applied. A bad feedback or shift path stays hidden while D is zero. During feedback accumulation, though, a single wrong term is carried forward into every later result, so the error grows cycle after cycle. A flaw in the overflow detection shows only when the sum leaves the 44-bit range. The bench therefore drives the addend and the cascade input near both extremes.

// File: rtl/macc_slice.sv
module macc_slice #(
  parameter int AW    = 18,
  parameter int PW    = 44,
  parameter int SHIFT = 17
) (
  input  logic          clk,
  input  logic          dotp,
  input  logic [AW-1:0] a,
  input  logic          a_byp,
  input  logic          a_arst_n,
  input  logic          a_srst_n,
  input  logic          a_en,
  input  logic [AW-1:0] b,
  input  logic          b_byp,
  input  logic          b_arst_n,
  input  logic          b_srst_n,
  input  logic          b_en,
  input  logic [PW-1:0] c,
  input  logic          cin,
  input  logic          c_byp,
  input  logic          c_arst_n,
  input  logic          c_srst_n,
  input  logic          c_en,
  input  logic [PW-1:0] cdin,
  input  logic [3:0]    ctl_d,
  input  logic [3:0]    ctl_byp,
  input  logic [3:0]    ctl_aload_n,
  input  logic [3:0]    ctl_aval,
  input  logic [3:0]    ctl_sload_n,
  input  logic [3:0]    ctl_sval_n,
  input  logic [3:0]    ctl_en,
  input  logic          p_byp,
  input  logic          p_arst_n,
  input  logic          p_srst_n,
  input  logic          p_en,
  output logic [PW-1:0] p,
  output logic [PW-1:0] cdout,
  output logic          ovfl
);
  localparam int HW    = AW / 2;
  localparam int NCTL  = 4;
  localparam int CW    = PW + 1;
  localparam int SW    = PW + 3;
  localparam int C_SUB = 0;
  localparam int C_CAS = 1;
  localparam int C_FB  = 2;
  localparam int C_SHR = 3;

  logic [AW-1:0] a_q, a_nxt, a_o;
  logic [AW-1:0] b_q, b_nxt, b_o;
  logic [CW-1:0] c_q, c_nxt, c_o;
  logic [CW-1:0] p_q, p_nxt, p_o;
  logic [NCTL-1:0] ctl_q, ctl_o;

  assign a_nxt = a_srst_n ? a : '0;
  always_ff @(posedge clk or negedge a_arst_n)
    if (!a_arst_n)  a_q <= '0;
    else if (a_en)  a_q <= a_nxt;
  assign a_o = !a_arst_n ? '0 : (a_byp && a_en) ? a_nxt : a_q;

  assign b_nxt = b_srst_n ? b : '0;
  always_ff @(posedge clk or negedge b_arst_n)
    if (!b_arst_n)  b_q <= '0;
    else if (b_en)  b_q <= b_nxt;
  assign b_o = !b_arst_n ? '0 : (b_byp && b_en) ? b_nxt : b_q;

  assign c_nxt = c_srst_n ? {cin, c} : '0;
  always_ff @(posedge clk or negedge c_arst_n)
    if (!c_arst_n)  c_q <= '0;
    else if (c_en)  c_q <= c_nxt;
  assign c_o = !c_arst_n ? '0 : (c_byp && c_en) ? c_nxt : c_q;

  for (genvar i = 0; i < NCTL; i++) begin : g_ctl
    logic q, nxt;
    assign nxt = ctl_sload_n[i] ? ctl_d[i] : ~ctl_sval_n[i];
    always_ff @(posedge clk or negedge ctl_aload_n[i])
      if (!ctl_aload_n[i]) q <= ctl_aval[i];
      else if (ctl_en[i])  q <= nxt;
    assign ctl_q[i] = q;
    assign ctl_o[i] = !ctl_aload_n[i] ? ctl_aval[i]
                    : (ctl_byp[i] && ctl_en[i]) ? nxt : q;
  end

  logic [PW-1:0] a_x, b_x, alo, blo, ahi, bhi, prod, dsrc, dval;
  assign a_x  = {{(PW-AW){a_o[AW-1]}}, a_o};
  assign b_x  = {{(PW-AW){b_o[AW-1]}}, b_o};
  assign alo  = {{(PW-HW){a_o[HW-1]}}, a_o[HW-1:0]};
  assign blo  = {{(PW-HW){b_o[HW-1]}}, b_o[HW-1:0]};
  assign ahi  = {{(PW-HW){a_o[AW-1]}}, a_o[AW-1:HW]};
  assign bhi  = {{(PW-HW){b_o[AW-1]}}, b_o[AW-1:HW]};
  assign prod = dotp ? (alo * blo + ahi * bhi) : (a_x * b_x);

  assign dsrc = ctl_o[C_CAS] ? cdin : ctl_o[C_FB] ? p_q[PW-1:0] : '0;
  assign dval = ctl_o[C_SHR] ? {{SHIFT{dsrc[PW-1]}}, dsrc[PW-1:SHIFT]} : dsrc;

  logic [SW-1:0] d_w, c_w, k_w, m_w, sum;
  logic          ovf;
  assign d_w = {{(SW-PW){dval[PW-1]}}, dval};
  assign c_w = {{(SW-PW){c_o[PW-1]}}, c_o[PW-1:0]};
  assign k_w = {{(SW-1){1'b0}}, c_o[PW]};
  assign m_w = ctl_o[C_SUB] ? -{{(SW-PW){prod[PW-1]}}, prod}
                            :  {{(SW-PW){prod[PW-1]}}, prod};
  assign sum = d_w + c_w + k_w + m_w;
  assign ovf = !((&sum[SW-1:PW-1]) || !(|sum[SW-1:PW-1]));

  assign p_nxt = p_srst_n ? {ovf, sum[PW-1:0]} : '0;
  always_ff @(posedge clk or negedge p_arst_n)
    if (!p_arst_n)  p_q <= '0;
    else if (p_en)  p_q <= p_nxt;
  assign p_o = !p_arst_n ? '0 : (p_byp && p_en) ? p_nxt : p_q;

  assign p     = p_o[PW-1:0];
  assign cdout = p_o[PW-1:0];
  assign ovfl  = p_o[PW];
endmodule

// File: rtl/macc_slice_chk.sv
module macc_slice_chk #(
  parameter int PW   = 44,
  parameter int NCTL = 4
) (
  input logic            clk,
  input logic            p_arst_n,
  input logic            p_en,
  input logic            p_srst_n,
  input logic            p_byp,
  input logic [PW-1:0]   p,
  input logic            ovfl,
  input logic [NCTL-1:0] ctl_q,
  input logic [NCTL-1:0] ctl_aload_n,
  input logic [NCTL-1:0] ctl_aval,
  input logic [NCTL-1:0] ctl_en,
  input logic [NCTL-1:0] ctl_sload_n,
  input logic [NCTL-1:0] ctl_sval_n
);
  always @(negedge clk)
    if (p_arst_n === 1'b0)
      // R1
      p_async_clear_chk: assert (p == '0 && ovfl == 1'b0);

  // R9
  p_hold_chk: assert property (@(posedge clk) disable iff (!p_arst_n)
    (!p_en && !p_byp) |=> (p_byp || $stable(p)));

  // R9
  p_sync_clear_chk: assert property (@(posedge clk) disable iff (!p_arst_n)
    (p_en && !p_srst_n && !p_byp) |=> (p_byp || (p == '0 && !ovfl)));

  // R10
  ctl_async_load_chk: assert property (@(posedge clk) disable iff (!p_arst_n)
    ((ctl_q ^ ctl_aval) & ~ctl_aload_n & ~$past(ctl_aload_n)
      & ~(ctl_aval ^ $past(ctl_aval))) == '0);

  // R10
  ctl_sync_load_chk: assert property (@(posedge clk) disable iff (!p_arst_n)
    ((ctl_q ^ ~$past(ctl_sval_n))
      & $past(ctl_en & ctl_aload_n & ~ctl_sload_n) & ctl_aload_n) == '0);
endmodule

bind macc_slice macc_slice_chk #(.PW(PW), .NCTL(4)) u_chk (
  .clk(clk), .p_arst_n(p_arst_n), .p_en(p_en), .p_srst_n(p_srst_n),
  .p_byp(p_byp), .p(p), .ovfl(ovfl), .ctl_q(ctl_q),
  .ctl_aload_n(ctl_aload_n), .ctl_aval(ctl_aval), .ctl_en(ctl_en),
  .ctl_sload_n(ctl_sload_n), .ctl_sval_n(ctl_sval_n)
);

// File: tb/macc_slice_test.sv
`timescale 1ns/1ps
module macc_slice_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic dotp;
  logic [17:0] a, b;
  logic a_byp, a_arst_n, a_srst_n, a_en;
  logic b_byp, b_arst_n, b_srst_n, b_en;
  logic [43:0] c, cdin;
  logic cin, c_byp, c_arst_n, c_srst_n, c_en;
  logic [3:0] ctl_d, ctl_byp, ctl_aload_n, ctl_aval, ctl_sload_n, ctl_sval_n, ctl_en;
  logic p_byp, p_arst_n, p_srst_n, p_en;
  logic [43:0] p, cdout;
  logic ovfl;

  macc_slice uut (
    .clk(clk), .dotp(dotp),
    .a(a), .a_byp(a_byp), .a_arst_n(a_arst_n), .a_srst_n(a_srst_n), .a_en(a_en),
    .b(b), .b_byp(b_byp), .b_arst_n(b_arst_n), .b_srst_n(b_srst_n), .b_en(b_en),
    .c(c), .cin(cin), .c_byp(c_byp), .c_arst_n(c_arst_n), .c_srst_n(c_srst_n), .c_en(c_en),
    .cdin(cdin), .ctl_d(ctl_d), .ctl_byp(ctl_byp), .ctl_aload_n(ctl_aload_n),
    .ctl_aval(ctl_aval), .ctl_sload_n(ctl_sload_n), .ctl_sval_n(ctl_sval_n), .ctl_en(ctl_en),
    .p_byp(p_byp), .p_arst_n(p_arst_n), .p_srst_n(p_srst_n), .p_en(p_en),
    .p(p), .cdout(cdout), .ovfl(ovfl)
  );

  int n_run = 0;
  int n_fail = 0;
  string cur = "R1";

  logic [17:0] ma = '0, mb = '0;
  logic [44:0] mc = '0, mp = '0;
  logic [3:0]  mctl = '0;

  function automatic longint sx9(logic [8:0] v);   return longint'($signed(v)); endfunction
  function automatic longint sx18(logic [17:0] v); return longint'($signed(v)); endfunction
  function automatic longint sx44(logic [43:0] v); return longint'($signed(v)); endfunction

  function automatic logic [44:0] dout(logic arst_n, logic byp, logic en, logic srst_n,
                                       logic [44:0] d, logic [44:0] q);
    if (!arst_n) return '0;
    if (byp && en) return srst_n ? d : '0;
    return q;
  endfunction

  function automatic logic cout(logic al_n, logic av, logic byp, logic en,
                                logic sl_n, logic sv_n, logic d, logic q);
    if (!al_n) return av;
    if (byp && en) return sl_n ? d : !sv_n;
    return q;
  endfunction

  function automatic logic [43:0] r44();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    return r[43:0];
  endfunction

  task automatic chk(logic ok, string req, logic [44:0] got, logic [44:0] exp, string what);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic cyc();
    logic [44:0] ea, eb, ec, ep, pin, na, nb, nc, np;
    logic [3:0] ectl, nctl;
    logic [43:0] src;
    longint pr, dv, tot, lim;
    #1;
    ea = dout(a_arst_n, a_byp, a_en, a_srst_n, 45'(a), 45'(ma));
    eb = dout(b_arst_n, b_byp, b_en, b_srst_n, 45'(b), 45'(mb));
    ec = dout(c_arst_n, c_byp, c_en, c_srst_n, {cin, c}, mc);
    for (int i = 0; i < 4; i++)
      ectl[i] = cout(ctl_aload_n[i], ctl_aval[i], ctl_byp[i], ctl_en[i],
                     ctl_sload_n[i], ctl_sval_n[i], ctl_d[i], mctl[i]);
    if (dotp) pr = sx9(ea[8:0]) * sx9(eb[8:0]) + sx9(ea[17:9]) * sx9(eb[17:9]);
    else      pr = sx18(ea[17:0]) * sx18(eb[17:0]);
    src = ectl[1] ? cdin : ectl[2] ? mp[43:0] : 44'd0;
    dv = sx44(src);
    if (ectl[3]) dv = dv >>> 17;
    tot = dv + sx44(ec[43:0]) + longint'(ec[44]) + (ectl[0] ? -pr : pr);
    lim = longint'(1) <<< 43;
    pin = {(tot >= lim) || (tot < -lim), tot[43:0]};
    ep = dout(p_arst_n, p_byp, p_en, p_srst_n, pin, mp);
    chk(p == ep[43:0], cur, 45'(p), 45'(ep[43:0]), "result");
    chk(ovfl == ep[44], cur, 45'(ovfl), 45'(ep[44]), "overflow flag");
    chk(cdout == p, "R7", 45'(cdout), 45'(p), "cascade copy");
    na = !a_arst_n ? '0 : a_en ? (a_srst_n ? 45'(a) : '0) : 45'(ma);
    nb = !b_arst_n ? '0 : b_en ? (b_srst_n ? 45'(b) : '0) : 45'(mb);
    nc = !c_arst_n ? '0 : c_en ? (c_srst_n ? {cin, c} : '0) : mc;
    np = !p_arst_n ? '0 : p_en ? (p_srst_n ? pin : '0) : mp;
    for (int i = 0; i < 4; i++)
      nctl[i] = !ctl_aload_n[i] ? ctl_aval[i]
              : ctl_en[i] ? (ctl_sload_n[i] ? ctl_d[i] : !ctl_sval_n[i]) : mctl[i];
    @(posedge clk);
    ma = na[17:0]; mb = nb[17:0]; mc = nc; mp = np; mctl = nctl;
    @(negedge clk);
  endtask

  task automatic rnd_data();
    a = 18'($urandom()); b = 18'($urandom());
    c = r44(); cin = 1'($urandom()); cdin = r44();
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual hung, expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    dotp = 0; a = '0; b = '0; c = '0; cin = 0; cdin = '0;
    {a_byp, b_byp, c_byp, p_byp} = '0;
    {a_arst_n, b_arst_n, c_arst_n, p_arst_n} = '0;
    {a_srst_n, b_srst_n, c_srst_n, p_srst_n} = '1;
    {a_en, b_en, c_en, p_en} = '1;
    ctl_d = '0; ctl_byp = '0; ctl_aload_n = '0; ctl_aval = '0;
    ctl_sload_n = '1; ctl_sval_n = '1; ctl_en = '1;
    @(negedge clk);
    cur = "R1";
    a = 18'd77; b = 18'd5; c = 44'd9;
    repeat (3) cyc();
    {a_arst_n, b_arst_n, c_arst_n, p_arst_n} = '1;
    ctl_aload_n = '1;

    cur = "R2";
    a = 18'd3; b = 18'h3FFFB; c = 44'd10; cin = 0; ctl_d = 4'b0000;
    cyc(); cyc();
    chk(p == 44'hFFFFFFFFFFB, "R2", 45'(p), 45'(44'hFFFFFFFFFFB), "3*-5+10 directed");
    for (int i = 0; i < 30; i++) begin rnd_data(); cyc(); end

    cur = "R3";
    for (int i = 0; i < 30; i++) begin rnd_data(); ctl_d[0] = 1'($urandom()); cyc(); end

    cur = "R4";
    dotp = 1;
    for (int i = 0; i < 30; i++) begin rnd_data(); ctl_d[0] = 1'($urandom()); cyc(); end
    dotp = 0;

    cur = "R5";
    for (int i = 0; i < 40; i++) begin
      rnd_data(); ctl_d = {1'b0, 3'($urandom())}; cyc();
    end
    ctl_d = 4'b0100;
    for (int i = 0; i < 12; i++) begin
      a = 18'($urandom_range(0, 200)); b = 18'($urandom_range(0, 200));
      c = 44'($urandom_range(0, 50)); cyc();
    end

    cur = "R6";
    for (int i = 0; i < 40; i++) begin
      rnd_data(); ctl_d = {1'b1, 3'($urandom())}; cyc();
    end

    cur = "R8";
    for (int i = 0; i < 40; i++) begin
      rnd_data();
      c = ($urandom() & 1) ? 44'h7FFFFFFFFF0 : 44'h80000000010;
      cdin = ($urandom() & 1) ? 44'h7FFFFFFFFFF : 44'h80000000000;
      a = ($urandom() & 1) ? 18'h1FFFF : 18'h20000;
      ctl_d = {1'b0, 1'($urandom()), 1'b0, 1'($urandom())};
      cyc();
    end

    cur = "R9";
    ctl_d = 4'b0000;
    for (int i = 0; i < 60; i++) begin
      rnd_data();
      {a_en, b_en, c_en, p_en} = 4'($urandom());
      {a_srst_n, b_srst_n, c_srst_n, p_srst_n} = 4'($urandom()) | 4'($urandom());
      a_arst_n = ($urandom_range(0, 9) != 0); c_arst_n = ($urandom_range(0, 9) != 0);
      p_arst_n = ($urandom_range(0, 9) != 0);
      cyc();
    end
    {a_en, b_en, c_en, p_en} = '1;
    {a_srst_n, b_srst_n, c_srst_n, p_srst_n} = '1;
    {a_arst_n, b_arst_n, c_arst_n, p_arst_n} = '1;

    cur = "R10";
    for (int i = 0; i < 60; i++) begin
      rnd_data();
      ctl_d = 4'($urandom()); ctl_en = 4'($urandom()); ctl_sload_n = 4'($urandom());
      ctl_sval_n = 4'($urandom()); ctl_aval = 4'($urandom());
      ctl_aload_n = 4'($urandom()) | 4'($urandom());
      cyc();
    end
    ctl_en = '1; ctl_sload_n = '1; ctl_aload_n = '1;

    cur = "R11";
    for (int k = 0; k < 8; k++) begin
      {a_byp, b_byp, c_byp, p_byp} = 4'($urandom());
      ctl_byp = 4'($urandom());
      for (int i = 0; i < 8; i++) begin
        rnd_data(); ctl_d = 4'($urandom());
        {a_en, b_en, c_en, p_en} = 4'($urandom()) | 4'($urandom());
        ctl_en = 4'($urandom()) | 4'($urandom());
        cyc();
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule